// File: doc/BRIEF.md
# Serial Receiver with Sticky Error Flags

This block takes an asynchronous serial line and turns each character on it into a byte that a host reads through a small register port. The line is oversampled by 16. An internal divider makes the oversampling tick from the system clock. A falling edge starts a frame, and each bit is sampled near its centre. The assembled byte is placed in a data register, and a full flag is raised in the status register.

The status register also holds two error flags, and both are sticky. An overrun flag records that a character finished while the previous one was still unread. A framing flag records that the stop bit was sampled low. While either flag is set, the receiver starts no new frame. Software clears a flag with a handshake: it first reads the status register and sees the flag at 1, then writes 0 to that flag's bit. Turning the receiver off leaves both flags untouched.

The host port uses plain register access: an address, a one-cycle read strobe, a one-cycle write strobe and write data. Read data is combinational from the address. The port has no valid/ready handshake and no back-pressure, because the host polls the full flag.

Top module: `srx_top`

## Requirements
- R1: After reset, the status register (address 1) and the control register (address 2) both read 0: full, overrun and framing flags are 0, and the receiver is off.
- R2: With the enable bit (control bit 0) at 1, a frame is accepted. A frame is one low start bit, 8 data bits least significant first, and a high stop bit, each lasting 16*CLK_DIV clocks. The byte then reads from address 0, and status bit 0 (full) reads 1.
- R3: A read of address 0 clears the full flag.
- R4: If a frame with a good stop bit ends while full is 1, status bit 1 (overrun) is set. Address 0 keeps the earlier byte, and the new byte is lost.
- R5: If the first stop bit is sampled low, status bit 2 (framing) is set. The received byte is still written to address 0, but full is not raised.
- R6: While the overrun or framing flag is 1, incoming frames are ignored: address 0 and the full flag do not change.
- R7: With control bit 1 at 1 (two stop bits), only the first stop bit is checked. A low second stop bit causes no error, and a low first stop bit still sets framing.
- R8: A flag clears only when a write to address 1 puts 0 in its bit after a status read returned that flag as 1. A write of 0 without such a read, or a write of 1, leaves the flag unchanged.
- R9: Writing control bit 0 to 0 changes neither error flag. While control bit 0 is 0, no frame is received.
- R10: A start edge is confirmed only if the line is still low at the middle of the start bit. A shorter low pulse is discarded, and a following frame is received normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd_i | input | 1 | Serial input line, idle high |
| bus_addr_i | input | 2 | Register address: 0 data, 1 status, 2 control |
| bus_wr_i | input | 1 | One-cycle write strobe |
| bus_rd_i | input | 1 | One-cycle read strobe (side effects on data and status reads) |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for the addressed register |

## Verification
The hardest state to reach from the ports is a sticky flag that is armed for clearing but has not yet been cleared. That state must be held while further frames, enable toggles and writes of the wrong value arrive. The bench first causes an overrun by sending two characters without reading. It then writes 0 before any status read, reads status, turns the receiver off and on, writes 1, and sends a third character. It checks after every step that the flag stays and the first byte is kept. Only then does it complete the clear. A framing error, a low second stop bit in two-stop mode, and a start glitch shorter than half a bit are driven directly on the line.

// File: rtl/srx_pkg.sv
package srx_pkg;
  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP,
    RX_GUARD
  } rx_state_e;

  localparam logic [1:0] ADDR_DATA = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_CTRL = 2'd2;

  localparam int ST_FULL = 0;
  localparam int ST_OVR  = 1;
  localparam int ST_FERR = 2;

  localparam int CT_EN  = 0;
  localparam int CT_TWO = 1;

  typedef struct packed {
    logic two_stop;
    logic enable;
  } ctrl_t;
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout,
  output logic fall
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '1;
    else        sh_q <= {sh_q[STAGES-1:0], din};
  end

  assign dout = sh_q[STAGES-1];
  assign fall = sh_q[STAGES] & ~sh_q[STAGES-1];
endmodule

// File: rtl/srx_baud.sv
module srx_baud #(
  parameter int CLK_DIV = 27
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLK_DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (clr)           cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick = (cnt_q == LAST) && !clr;
endmodule

// File: rtl/srx_frame.sv
module srx_frame
  import srx_pkg::*;
#(
  parameter int OVS   = 16,
  parameter int NBITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line,
  input  logic             fall,
  input  logic             tick,
  input  logic             enable,
  input  logic             two_stop,
  input  logic             blocked,
  output logic             tick_clr,
  output logic             done,
  output logic             stop_ok,
  output logic [NBITS-1:0] data
);
  localparam int TCW = $clog2(OVS);
  localparam int BCW = (NBITS > 1) ? $clog2(NBITS) : 1;
  localparam logic [TCW-1:0] MID  = TCW'(OVS / 2 - 1);
  localparam logic [TCW-1:0] TEND = TCW'(OVS - 1);
  localparam logic [BCW-1:0] BEND = BCW'(NBITS - 1);

  rx_state_e        state_q;
  logic [TCW-1:0]   tcnt_q;
  logic [BCW-1:0]   bcnt_q;
  logic [NBITS-1:0] shreg_q;
  logic             done_q;
  logic             stop_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      tcnt_q  <= '0;
      bcnt_q  <= '0;
      shreg_q <= '0;
      done_q  <= 1'b0;
      stop_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (state_q != RX_IDLE && !enable) begin
        state_q <= RX_IDLE;
        tcnt_q  <= '0;
      end else begin
        unique case (state_q)
          RX_IDLE: begin
            tcnt_q <= '0;
            if (enable && !blocked && fall) state_q <= RX_START;
          end
          RX_START: if (tick) begin
            if (tcnt_q == MID) begin
              tcnt_q  <= '0;
              bcnt_q  <= '0;
              state_q <= line ? RX_IDLE : RX_DATA;
            end else begin
              tcnt_q <= tcnt_q + 1'b1;
            end
          end
          RX_DATA: if (tick) begin
            if (tcnt_q == TEND) begin
              tcnt_q  <= '0;
              shreg_q <= {line, shreg_q[NBITS-1:1]};
              if (bcnt_q == BEND) state_q <= RX_STOP;
              else                bcnt_q  <= bcnt_q + 1'b1;
            end else begin
              tcnt_q <= tcnt_q + 1'b1;
            end
          end
          RX_STOP: if (tick) begin
            if (tcnt_q == TEND) begin
              tcnt_q  <= '0;
              done_q  <= 1'b1;
              stop_q  <= line;
              state_q <= two_stop ? RX_GUARD : RX_IDLE;
            end else begin
              tcnt_q <= tcnt_q + 1'b1;
            end
          end
          RX_GUARD: if (tick) begin
            if (tcnt_q == TEND) begin
              tcnt_q  <= '0;
              state_q <= RX_IDLE;
            end else begin
              tcnt_q <= tcnt_q + 1'b1;
            end
          end
          default: state_q <= RX_IDLE;
        endcase
      end
    end
  end

  assign tick_clr = (state_q == RX_IDLE);
  assign done     = done_q;
  assign stop_ok  = stop_q;
  assign data     = shreg_q;
endmodule

// File: rtl/srx_regs.sv
module srx_regs
  import srx_pkg::*;
#(
  parameter int NBITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       addr,
  input  logic             wr,
  input  logic             rd,
  input  logic [NBITS-1:0] wdata,
  input  logic             done,
  input  logic             stop_ok,
  input  logic [NBITS-1:0] rx_byte,
  output logic [NBITS-1:0] rdata,
  output ctrl_t            ctrl,
  output logic             blocked,
  output logic             full,
  output logic             ovr,
  output logic             ferr,
  output logic [NBITS-1:0] data_q
);
  logic rd_data, rd_stat, wr_stat, wr_ctrl;
  logic good_load, ovr_evt, ferr_evt;
  logic arm_ovr_q, arm_ferr_q;
  logic clr_ovr, clr_ferr;
  logic full_q, ovr_q, ferr_q;
  logic [NBITS-1:0] dreg_q;
  ctrl_t ctrl_q;

  assign rd_data = rd && (addr == ADDR_DATA);
  assign rd_stat = rd && (addr == ADDR_STAT);
  assign wr_stat = wr && (addr == ADDR_STAT);
  assign wr_ctrl = wr && (addr == ADDR_CTRL);

  // a read in the completion cycle frees the register for the new byte
  assign good_load = done && stop_ok && (!full_q || rd_data);
  assign ovr_evt   = done && stop_ok && full_q && !rd_data;
  assign ferr_evt  = done && !stop_ok;

  assign clr_ovr  = wr_stat && !wdata[ST_OVR]  && arm_ovr_q;
  assign clr_ferr = wr_stat && !wdata[ST_FERR] && arm_ferr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dreg_q     <= '0;
      full_q     <= 1'b0;
      ovr_q      <= 1'b0;
      ferr_q     <= 1'b0;
      arm_ovr_q  <= 1'b0;
      arm_ferr_q <= 1'b0;
      ctrl_q     <= '0;
    end else begin
      if (good_load || ferr_evt) dreg_q <= rx_byte;

      if (good_load)    full_q <= 1'b1;
      else if (rd_data) full_q <= 1'b0;

      if (ovr_evt)      ovr_q <= 1'b1;
      else if (clr_ovr) ovr_q <= 1'b0;

      if (ferr_evt)      ferr_q <= 1'b1;
      else if (clr_ferr) ferr_q <= 1'b0;

      if (clr_ovr)               arm_ovr_q <= 1'b0;
      else if (rd_stat && ovr_q) arm_ovr_q <= 1'b1;

      if (clr_ferr)               arm_ferr_q <= 1'b0;
      else if (rd_stat && ferr_q) arm_ferr_q <= 1'b1;

      if (wr_ctrl) begin
        ctrl_q.enable   <= wdata[CT_EN];
        ctrl_q.two_stop <= wdata[CT_TWO];
      end
    end
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      ADDR_DATA: rdata = dreg_q;
      ADDR_STAT: begin
        rdata[ST_FULL] = full_q;
        rdata[ST_OVR]  = ovr_q;
        rdata[ST_FERR] = ferr_q;
      end
      ADDR_CTRL: begin
        rdata[CT_EN]  = ctrl_q.enable;
        rdata[CT_TWO] = ctrl_q.two_stop;
      end
      default: rdata = '0;
    endcase
  end

  assign ctrl    = ctrl_q;
  assign blocked = ovr_q | ferr_q;
  assign full    = full_q;
  assign ovr     = ovr_q;
  assign ferr    = ferr_q;
  assign data_q  = dreg_q;
endmodule

// File: rtl/srx_top.sv
module srx_top
  import srx_pkg::*;
#(
  parameter int CLK_DIV = 27,
  parameter int OVS     = 16,
  parameter int NBITS   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rxd_i,
  input  logic [1:0]       bus_addr_i,
  input  logic             bus_wr_i,
  input  logic             bus_rd_i,
  input  logic [NBITS-1:0] bus_wdata_i,
  output logic [NBITS-1:0] bus_rdata_o
);
  logic             line_s, fall_s, tick_s, tick_clr_s;
  logic             done_s, stop_ok_s, blocked_s;
  logic             full_s, ovr_s, ferr_s;
  logic [NBITS-1:0] rx_byte_s, data_s;
  ctrl_t            ctrl_s;

  srx_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rxd_i), .dout(line_s), .fall(fall_s)
  );

  srx_baud #(.CLK_DIV(CLK_DIV)) u_baud (
    .clk(clk), .rst_n(rst_n), .clr(tick_clr_s), .tick(tick_s)
  );

  srx_frame #(.OVS(OVS), .NBITS(NBITS)) u_frame (
    .clk(clk), .rst_n(rst_n), .line(line_s), .fall(fall_s), .tick(tick_s),
    .enable(ctrl_s.enable), .two_stop(ctrl_s.two_stop), .blocked(blocked_s),
    .tick_clr(tick_clr_s), .done(done_s), .stop_ok(stop_ok_s), .data(rx_byte_s)
  );

  srx_regs #(.NBITS(NBITS)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr_i), .wr(bus_wr_i), .rd(bus_rd_i),
    .wdata(bus_wdata_i), .done(done_s), .stop_ok(stop_ok_s), .rx_byte(rx_byte_s),
    .rdata(bus_rdata_o), .ctrl(ctrl_s), .blocked(blocked_s), .full(full_s),
    .ovr(ovr_s), .ferr(ferr_s), .data_q(data_s)
  );
endmodule

// File: rtl/srx_chk.sv
module srx_chk
  import srx_pkg::*;
#(
  parameter int NBITS = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       bus_addr,
  input logic             bus_wr,
  input logic             bus_rd,
  input logic [NBITS-1:0] bus_wdata,
  input logic             done,
  input logic             stop_ok,
  input logic             full,
  input logic             ovr,
  input logic             ferr,
  input logic [NBITS-1:0] data
);
  // R3: a data read with no completion in the same cycle empties the register
  p_full_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == ADDR_DATA && !done) |=> !full);

  // R4: overrun keeps the earlier byte
  p_ovr_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> ($stable(data) && $past(done)));

  // R5: a framing error never raises full
  p_ferr_nofull_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ferr) |-> (!$rose(full) && $past(done) && !$past(stop_ok)));

  // R6: no completion and no data change while a flag is set
  p_blocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr || ferr) |-> !done);
  p_blocked_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr || ferr) |=> $stable(data));

  // R8: a flag falls only through a status write with its bit at 0
  p_ovr_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovr) |-> $past(bus_wr && bus_addr == ADDR_STAT && !bus_wdata[ST_OVR]));
  p_ferr_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ferr) |-> $past(bus_wr && bus_addr == ADDR_STAT && !bus_wdata[ST_FERR]));

  // R9: control writes leave the error flags alone
  p_ctrl_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_CTRL && !done) |=> ($stable(ovr) && $stable(ferr)));
endmodule

bind srx_top srx_chk #(.NBITS(NBITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr_i), .bus_wr(bus_wr_i),
  .bus_rd(bus_rd_i), .bus_wdata(bus_wdata_i), .done(done_s),
  .stop_ok(stop_ok_s), .full(full_s), .ovr(ovr_s), .ferr(ferr_s), .data(data_s)
);

// File: tb/srx_top_tb.sv
`timescale 1ns/1ps
module srx_top_tb;
  localparam int DIV = 4;
  localparam int BIT = 16 * DIV;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rxd = 1'b1;
  logic [1:0] addr = '0;
  logic       wr = 1'b0;
  logic       rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];

  always #2.5 clk = ~clk;

  srx_top #(.CLK_DIV(DIV), .OVS(16), .NBITS(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .rxd_i(rxd), .bus_addr_i(addr), .bus_wr_i(wr),
    .bus_rd_i(rd), .bus_wdata_i(wdata), .bus_rdata_o(rdata)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  // driver: puts one frame on the line, pushes the byte if it must be delivered
  task automatic send_frame(input logic [7:0] b, input logic s1, input logic s2,
                            input bit two, input bit deliver);
    if (deliver) exp_q.push_back(b);
    rxd = 1'b0;
    repeat (BIT) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      repeat (BIT) @(negedge clk);
    end
    rxd = s1;
    repeat (BIT) @(negedge clk);
    if (two) begin
      rxd = s2;
      repeat (BIT) @(negedge clk);
    end
    rxd = 1'b1;
    repeat (20) @(negedge clk);
  endtask

  // monitor: pulls the byte out of the block and compares it with the queue
  task automatic collect(input string req);
    logic [7:0] st, d, e;
    bus_read(2'd1, st);
    chk({req, " full before read"}, {7'd0, st[0]}, 8'h01);
    bus_read(2'd0, d);
    if (exp_q.size() == 0) begin
      chk({req, " unexpected byte"}, d, 8'hxx);
    end else begin
      e = exp_q.pop_front();
      chk({req, " byte"}, d, e);
    end
    bus_read(2'd1, st);
    chk("R3 full cleared by data read", {7'd0, st[0]}, 8'h00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    bus_read(2'd1, v); chk("R1 status after reset", v, 8'h00);
    bus_read(2'd2, v); chk("R1 control after reset", v, 8'h00);

    // R9: receiver off ignores the line
    send_frame(8'h5A, 1'b1, 1'b1, 0, 0);
    bus_read(2'd1, v); chk("R9 disabled receives nothing", v, 8'h00);

    bus_write(2'd2, 8'h01);
    bus_read(2'd2, v); chk("R2 control enable readback", v, 8'h01);
    foreach (exp_q[i]) exp_q.delete(i);
    send_frame(8'hA5, 1'b1, 1'b1, 0, 1); collect("R2 pattern A5");
    send_frame(8'h00, 1'b1, 1'b1, 0, 1); collect("R2 pattern 00");
    send_frame(8'hFF, 1'b1, 1'b1, 0, 1); collect("R2 pattern FF");
    send_frame(8'h3C, 1'b1, 1'b1, 0, 1); collect("R2 pattern 3C");
    send_frame(8'h81, 1'b1, 1'b1, 0, 1); collect("R2 pattern 81");

    // R10: short low pulse
    rxd = 1'b0;
    repeat (4 * DIV) @(negedge clk);
    rxd = 1'b1;
    repeat (3 * BIT) @(negedge clk);
    bus_read(2'd1, v); chk("R10 glitch rejected", v, 8'h00);
    send_frame(8'h66, 1'b1, 1'b1, 0, 1); collect("R10 frame after glitch");

    // R4 overrun, R8 clear handshake, R6 blocking, R9 enable toggle
    send_frame(8'h11, 1'b1, 1'b1, 0, 1);
    send_frame(8'h22, 1'b1, 1'b1, 0, 0);
    bus_write(2'd1, 8'h00);
    bus_read(2'd1, v); chk("R8 unarmed write keeps overrun", v, 8'h03);
    chk("R4 overrun flag set", v & 8'h02, 8'h02);
    bus_write(2'd2, 8'h00);
    bus_read(2'd1, v); chk("R9 disable keeps overrun", v, 8'h03);
    bus_write(2'd2, 8'h01);
    bus_write(2'd1, 8'h02);
    bus_read(2'd1, v); chk("R8 write of one keeps overrun", v, 8'h03);
    send_frame(8'h33, 1'b1, 1'b1, 0, 0);
    bus_read(2'd1, v); chk("R6 frame ignored under overrun", v, 8'h03);
    collect("R4 earlier byte kept");
    send_frame(8'h44, 1'b1, 1'b1, 0, 0);
    bus_read(2'd1, v); chk("R6 empty register stays empty", v, 8'h02);
    bus_write(2'd1, 8'h00);
    bus_read(2'd1, v); chk("R8 armed write clears overrun", v, 8'h00);
    send_frame(8'h44, 1'b1, 1'b1, 0, 1); collect("R8 reception resumes");

    // R5 framing
    send_frame(8'hC3, 1'b0, 1'b1, 0, 0);
    bus_read(2'd1, v); chk("R5 framing set, full clear", v, 8'h04);
    bus_read(2'd0, v); chk("R5 byte written on framing error", v, 8'hC3);
    send_frame(8'h55, 1'b1, 1'b1, 0, 0);
    bus_read(2'd0, v); chk("R6 data kept under framing", v, 8'hC3);
    bus_read(2'd1, v); chk("R6 status kept under framing", v, 8'h04);
    bus_write(2'd2, 8'h00);
    bus_read(2'd1, v); chk("R9 disable keeps framing", v, 8'h04);
    bus_write(2'd1, 8'h00);
    bus_read(2'd1, v); chk("R8 framing cleared", v, 8'h00);

    // R7 two stop bits
    bus_write(2'd2, 8'h03);
    send_frame(8'h9C, 1'b1, 1'b0, 1, 1); collect("R7 second stop ignored");
    bus_read(2'd1, v); chk("R7 no error on low second stop", v, 8'h00);
    send_frame(8'h27, 1'b0, 1'b1, 1, 0);
    bus_read(2'd1, v); chk("R7 first stop still checked", v, 8'h04);
    bus_write(2'd1, 8'h00);
    bus_read(2'd1, v); chk("R8 framing cleared again", v, 8'h00);

    chk("R2 scoreboard drained", 8'(exp_q.size()), 8'h00);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule